// File: doc/BRIEF.md
# Odd/Even Pixel Merge with Per-Channel Black Clamp

This block sits behind the digitisers of one colour of a linear image sensor. The sensor reads each line out on two channels at once, one carrying the odd-numbered pixels and one carrying the even-numbered pixels. A timing generator presents each digitised odd/even pair with a strobe and marks the first pair of every line with a sync flag. The block counts pairs against a fixed readout map that tags every pixel as dummy, optical black, invalid or valid. It rebuilds a single pixel stream in sensor order, odd pixel first.

The two channels do not share an output amplifier, so each one has its own dark offset. The block averages the optical black samples of each channel separately. It then subtracts each channel's own average from that channel's valid pixels, so the mismatch between odd and even pixels is removed. Corrected values saturate at zero. Only valid pixels leave the block, each for a single cycle with a valid strobe and a ready input. A last flag marks the final pixel of the line. A pixel that is presented while ready is low is lost, and a sticky overflow flag records the loss.

Top module: `oddeven_black_merge`

## Requirements
- R1: A pair captured on a clock edge with `pair_stb` high and tagged valid produces its odd pixel on the outputs from that edge and its even pixel from the next edge, each for one cycle with `pix_valid` high.
- R2: Pair index 0 is the pair strobed together with `line_sync`. With the default map, pixel numbers 1–26 are dummy, 27–122 optical black, 123–128 invalid, 129–7428 valid and 7429–7434 invalid; every later pixel is dummy. Exactly 7300 pixels per line are forwarded, and only valid ones.
- R3: Each channel's black level is floor(sum of its 48 optical black samples / 48), kept separately for the odd and the even channel and subtracted only from pixels of the same channel.
- R4: The black level used on the valid pixels of a line is the one measured in the optical black region of that same line. It changes only on the edge that captures the last optical black pair.
- R5: When the black level exceeds a sample, the corrected pixel is 0.
- R6: `pix_last` is high with the 7300th forwarded pixel of a line and at no other time.
- R7: A pixel presented while `pix_ready` is low is dropped and `overflow` becomes 1 on the following edge. `overflow` stays 1 until reset.
- R8: Pairs strobed after reset but before the first `line_sync` are treated as dummy and produce no output.
- R9: While reset is applied and after it is released, `pix_valid`, `pix_last` and `overflow` are 0.
- R10: `pair_stb` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pair_stb | input | 1 | A new odd/even sample pair is present |
| line_sync | input | 1 | With `pair_stb`: this pair is index 0 of a line |
| odd_smp | input | DATA_W | Odd-channel sample |
| even_smp | input | DATA_W | Even-channel sample |
| pix_ready | input | 1 | Downstream accepts the pixel presented this cycle |
| pix_valid | output | 1 | A corrected valid pixel is presented |
| pix_data | output | DATA_W | Black-corrected pixel value |
| pix_last | output | 1 | Presented pixel is the last valid pixel of the line |
| overflow | output | 1 | Sticky flag: at least one pixel was dropped |

## Verification
A pair strobed on one edge shows its odd pixel after that same edge and its even pixel one edge later. The bench drives inputs two nanoseconds after a rising edge and samples outputs at the following falling edge, so each result is read in the cycle it is due. The black level only takes effect after the last optical black pair, and valid pixels begin three pairs later, so every forwarded pixel of a line is compared against the mean that the bench computes from that line's own black samples. A dropped pixel is judged on the edge that ends its cycle, with the ready level the bench holds during that cycle. The overflow flag is therefore checked after the drop window, and the count of accepted pixels is compared with the number of presentations that had ready high.

// File: rtl/oem_pkg.sv
package oem_pkg;
  typedef enum logic [1:0] {
    RGN_DUMMY   = 2'd0,
    RGN_BLACK   = 2'd1,
    RGN_INVALID = 2'd2,
    RGN_VALID   = 2'd3
  } region_e;
endpackage

// File: rtl/oem_region_map.sv
module oem_region_map
  import oem_pkg::*;
#(
  parameter int unsigned N_LEAD_DUMMY = 26,
  parameter int unsigned N_BLACK      = 96,
  parameter int unsigned N_INV_HEAD   = 6,
  parameter int unsigned N_VALID      = 7300,
  parameter int unsigned N_INV_TAIL   = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pair_stb,
  input  logic    line_sync,
  output region_e region,
  output logic    first_black,
  output logic    last_black,
  output logic    last_valid
);
  // pair-index boundaries (each region holds an even pixel count)
  localparam int unsigned P_BLK0 = N_LEAD_DUMMY / 2;
  localparam int unsigned P_INV0 = P_BLK0 + N_BLACK / 2;
  localparam int unsigned P_VAL0 = P_INV0 + N_INV_HEAD / 2;
  localparam int unsigned P_INV1 = P_VAL0 + N_VALID / 2;
  localparam int unsigned P_END  = P_INV1 + N_INV_TAIL / 2;
  localparam int unsigned IDX_W  = $clog2(P_END + 1);

  localparam logic [IDX_W-1:0] IB0  = IDX_W'(P_BLK0);
  localparam logic [IDX_W-1:0] II0  = IDX_W'(P_INV0);
  localparam logic [IDX_W-1:0] IV0  = IDX_W'(P_VAL0);
  localparam logic [IDX_W-1:0] II1  = IDX_W'(P_INV1);
  localparam logic [IDX_W-1:0] IEND = IDX_W'(P_END);

  logic [IDX_W-1:0] idx_q, idx_d, cur;
  logic             idx_en;

  always_comb begin
    cur    = (pair_stb && line_sync) ? '0 : idx_q;
    idx_en = pair_stb;
    idx_d  = (cur == IEND) ? cur : cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= IEND;   // no line seen yet: everything is dummy
    else if (idx_en) idx_q <= idx_d;
  end

  always_comb begin
    if (cur < IB0)       region = RGN_DUMMY;
    else if (cur < II0)  region = RGN_BLACK;
    else if (cur < IV0)  region = RGN_INVALID;
    else if (cur < II1)  region = RGN_VALID;
    else if (cur < IEND) region = RGN_INVALID;
    else                 region = RGN_DUMMY;
    first_black = (cur == IB0);
    last_black  = (cur == II0 - 1'b1);
    last_valid  = (cur == II1 - 1'b1);
  end

  AST_PAIR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> !pair_stb);  // R10

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IEND);  // R2
endmodule

// File: rtl/oem_black_level.sv
module oem_black_level #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned N_BLK_CH = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_stb,
  input  logic              in_black,
  input  logic              first_pair,
  input  logic              last_pair,
  input  logic [DATA_W-1:0] smp,
  output logic [DATA_W-1:0] level
);
  localparam int unsigned SUM_W = DATA_W + $clog2(N_BLK_CH + 1);

  logic [SUM_W-1:0]  acc_q, acc_d, acc_sum;
  logic [DATA_W-1:0] lvl_q, lvl_d;
  logic              acc_en, lvl_en;

  always_comb begin
    acc_en  = pair_stb && in_black;
    lvl_en  = pair_stb && in_black && last_pair;
    acc_sum = (first_pair ? '0 : acc_q) + SUM_W'(smp);
    acc_d   = acc_sum;
    lvl_d   = DATA_W'(acc_sum / SUM_W'(N_BLK_CH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign level = lvl_q;

  AST_LEVEL_UPDATE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(pair_stb && last_pair));  // R4
endmodule

// File: rtl/oem_out_stage.sv
module oem_out_stage #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_stb,
  input  logic              is_valid,
  input  logic              last_pair,
  input  logic [DATA_W-1:0] odd_smp,
  input  logic [DATA_W-1:0] even_smp,
  input  logic [DATA_W-1:0] odd_lvl,
  input  logic [DATA_W-1:0] even_lvl,
  input  logic              pix_ready,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_last,
  output logic              overflow
);
  function automatic logic [DATA_W-1:0] sat_sub(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return (a > b) ? a - b : '0;
  endfunction

  logic              vld_q, vld_d, last_q, last_d, hold_q, hold_d;
  logic              hlast_q, hlast_d, ovf_q, ovf_d;
  logic [DATA_W-1:0] data_q, data_d, hdata_q, hdata_d;
  logic              data_en, hdata_en;

  always_comb begin
    vld_d    = 1'b0;
    last_d   = 1'b0;
    hold_d   = 1'b0;
    data_d   = data_q;
    hdata_d  = hdata_q;
    hlast_d  = hlast_q;
    data_en  = 1'b0;
    hdata_en = 1'b0;
    if (pair_stb && is_valid) begin
      vld_d    = 1'b1;
      data_d   = sat_sub(odd_smp, odd_lvl);
      data_en  = 1'b1;
      hold_d   = 1'b1;
      hdata_d  = sat_sub(even_smp, even_lvl);
      hlast_d  = last_pair;
      hdata_en = 1'b1;
    end else if (hold_q) begin
      vld_d   = 1'b1;
      data_d  = hdata_q;
      last_d  = hlast_q;
      data_en = 1'b1;
    end
    ovf_d = ovf_q | (vld_q & ~pix_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      hold_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      last_q <= last_d;
      hold_q <= hold_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdata_q <= '0;
      hlast_q <= 1'b0;
    end else if (hdata_en) begin
      hdata_q <= hdata_d;
      hlast_q <= hlast_d;
    end
  end

  assign pix_valid = vld_q;
  assign pix_data  = data_q;
  assign pix_last  = last_q;
  assign overflow  = ovf_q;

  AST_EVEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && hold_q) |=> vld_q);  // R1
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> vld_q);  // R6
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !pix_ready) |=> ovf_q);  // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);  // R7
endmodule

// File: rtl/oddeven_black_merge.sv
module oddeven_black_merge
  import oem_pkg::*;
#(
  parameter int unsigned DATA_W       = 12,
  parameter int unsigned N_LEAD_DUMMY = 26,
  parameter int unsigned N_BLACK      = 96,
  parameter int unsigned N_INV_HEAD   = 6,
  parameter int unsigned N_VALID      = 7300,
  parameter int unsigned N_INV_TAIL   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_stb,
  input  logic              line_sync,
  input  logic [DATA_W-1:0] odd_smp,
  input  logic [DATA_W-1:0] even_smp,
  input  logic              pix_ready,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_last,
  output logic              overflow
);
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned N_BLK_CH = N_BLACK / NUM_CH;

  // reset: asserted asynchronously, released on the second clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  region_e           rgn;
  logic              fb, lb, lv;
  logic [DATA_W-1:0] smp_ch [NUM_CH];
  logic [DATA_W-1:0] lvl_ch [NUM_CH];

  assign smp_ch[0] = odd_smp;
  assign smp_ch[1] = even_smp;

  oem_region_map #(
    .N_LEAD_DUMMY(N_LEAD_DUMMY), .N_BLACK(N_BLACK), .N_INV_HEAD(N_INV_HEAD),
    .N_VALID(N_VALID), .N_INV_TAIL(N_INV_TAIL)
  ) u_map (
    .clk(clk), .rst_n(rst_s2_q), .pair_stb(pair_stb), .line_sync(line_sync),
    .region(rgn), .first_black(fb), .last_black(lb), .last_valid(lv)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_blk
    oem_black_level #(.DATA_W(DATA_W), .N_BLK_CH(N_BLK_CH)) u_lvl (
      .clk(clk), .rst_n(rst_s2_q), .pair_stb(pair_stb),
      .in_black(rgn == RGN_BLACK), .first_pair(fb), .last_pair(lb),
      .smp(smp_ch[c]), .level(lvl_ch[c])
    );
  end

  oem_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_s2_q), .pair_stb(pair_stb),
    .is_valid(rgn == RGN_VALID), .last_pair(lv),
    .odd_smp(odd_smp), .even_smp(even_smp),
    .odd_lvl(lvl_ch[0]), .even_lvl(lvl_ch[1]),
    .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_last(pix_last), .overflow(overflow)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s2_q |-> (!pix_valid && !pix_last && !overflow));  // R9
  AST_NOTHING_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (pair_stb && !line_sync && rgn != RGN_VALID && !pix_valid) |=> !pix_valid);  // R2
endmodule

// File: tb/tb_oddeven_black_merge.sv
module tb_oddeven_black_merge;
  localparam int DW      = 12;
  localparam int N_PAIRS = 3719;   // full map (3717 pairs) plus two trailing dummies
  localparam int NV      = 7300;

  logic clk = 1'b0;
  logic rst_n, pair_stb, line_sync, pix_ready;
  logic [DW-1:0] odd_smp, even_smp;
  logic pix_valid, pix_last, overflow;
  logic [DW-1:0] pix_data;

  int checks = 0, errors = 0;
  int cur_line;
  int base_odd [4] = '{200, 900, 0, 500};
  int base_even[4] = '{260, 50, 4000, 500};
  int cur_lvl[2];
  int mon_idx, mon_bad, mon_last_cnt, mon_last_idx, mon_acc, mon_zero;
  int bad_act, bad_exp;

  always #4 clk = ~clk;

  oddeven_black_merge dut (
    .clk(clk), .rst_n(rst_n), .pair_stb(pair_stb), .line_sync(line_sync),
    .odd_smp(odd_smp), .even_smp(even_smp), .pix_ready(pix_ready),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_last(pix_last),
    .overflow(overflow)
  );

  function automatic int smp(int line, int ch, int p);
    if (p >= 13 && p < 61)
      return (ch != 0 ? base_even[line] : base_odd[line]) + ((p * 7 + ch * 3) % 9);
    return (p * 37 + ch * 1001 + line * 613) % 4096;
  endfunction

  function automatic int calc_lvl(int line, int ch);
    int sum = 0;
    for (int p = 13; p < 61; p++) sum += smp(line, ch, p);
    return sum / 48;
  endfunction

  function automatic int exp_pix(int j);
    int p, ch, s;
    p  = 64 + (j - 1) / 2;
    ch = (j - 1) % 2;
    s  = smp(cur_line, ch, p);
    return (s > cur_lvl[ch]) ? s - cur_lvl[ch] : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: outputs read at the falling edge
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      int e;
      mon_idx++;
      e = (mon_idx <= NV) ? exp_pix(mon_idx) : -1;
      if (int'(pix_data) != e) begin
        if (mon_bad == 0) begin bad_act = int'(pix_data); bad_exp = e; end
        mon_bad++;
      end
      if (e == 0) mon_zero++;
      if (pix_last) begin mon_last_cnt++; mon_last_idx = mon_idx; end
      if (pix_ready) mon_acc++;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic clear_mon();
    mon_idx = 0; mon_bad = 0; mon_last_cnt = 0; mon_last_idx = 0;
    mon_acc = 0; mon_zero = 0; bad_act = 0; bad_exp = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pair_stb = 1'b0; line_sync = 1'b0;
    odd_smp = '0; even_smp = '0; pix_ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    clear_mon();
  endtask

  task automatic t_reset_state();  // R9
    @(negedge clk);
    chk(pix_valid == 1'b0, "R9 pix_valid after reset", int'(pix_valid), 0);
    chk(pix_last == 1'b0, "R9 pix_last after reset", int'(pix_last), 0);
    chk(overflow == 1'b0, "R9 overflow after reset", int'(overflow), 0);
  endtask

  task automatic t_pre_sync();  // R8
    cur_line = 0;
    clear_mon();
    for (int p = 0; p < 80; p++) begin
      tick();
      pair_stb = 1'b1; line_sync = 1'b0;
      odd_smp = DW'(smp(0, 0, p)); even_smp = DW'(smp(0, 1, p));
      tick();
      pair_stb = 1'b0;
    end
    repeat (4) tick();
    chk(mon_idx == 0, "R8 no output before first line_sync", mon_idx, 0);
  endtask

  task automatic send_line(input int line, input int drop_lo, input int drop_hi);
    cur_line   = line;
    cur_lvl[0] = calc_lvl(line, 0);
    cur_lvl[1] = calc_lvl(line, 1);
    clear_mon();
    for (int p = 0; p < N_PAIRS; p++) begin
      tick();
      pair_stb  = 1'b1;
      line_sync = (p == 0);
      odd_smp   = DW'(smp(line, 0, p));
      even_smp  = DW'(smp(line, 1, p));
      pix_ready = !(p >= drop_lo && p <= drop_hi);
      tick();
      pair_stb = 1'b0; line_sync = 1'b0;
      if (p == 64) begin
        @(negedge clk);  // odd pixel of the first valid pair is due now
        chk(pix_valid && int'(pix_data) == exp_pix(1), "R1 odd pixel one edge after strobe",
            int'(pix_data), exp_pix(1));
        @(negedge clk);  // even pixel one edge later
        chk(pix_valid && int'(pix_data) == exp_pix(2), "R1 even pixel on the next edge",
            int'(pix_data), exp_pix(2));
      end
    end
    pix_ready = 1'b1;
    repeat (6) tick();
    chk(mon_idx == NV, "R2 forwarded pixel count", mon_idx, NV);
    chk(mon_bad == 0, "R3 per-channel black-corrected data", bad_act, bad_exp);
    chk(mon_last_cnt == 1 && mon_last_idx == NV, "R6 last flag position", mon_last_idx, NV);
  endtask

  task automatic t_line_basic();  // R1 R2 R3 R6
    send_line(0, -1, -1);
    chk(overflow == 1'b0, "R7 no overflow with ready high", int'(overflow), 0);
  endtask

  task automatic t_line_relevel();  // R4: new black levels, same-line use
    send_line(1, -1, -1);
    chk(mon_bad == 0, "R4 level of this line applied", bad_act, bad_exp);
    chk(mon_zero > 0, "R5 saturated pixels occurred", mon_zero, 1);
  endtask

  task automatic t_line_sat();  // R5: even black above most samples
    send_line(2, -1, -1);
    chk(mon_bad == 0 && mon_zero > 1000, "R5 clamp at zero", mon_zero, 1001);
  endtask

  task automatic t_overflow();  // R7
    send_line(3, 200, 204);
    chk(mon_acc == NV - 10, "R7 accepted pixels with drop window", mon_acc, NV - 10);
    chk(overflow == 1'b1, "R7 overflow raised", int'(overflow), 1);
    repeat (20) tick();
    @(negedge clk);
    chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
    do_reset();
    @(negedge clk);
    chk(overflow == 1'b0, "R9 overflow cleared by reset", int'(overflow), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_pre_sync();
    t_line_basic();
    t_line_relevel();
    t_line_sat();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule